// File: doc/BRIEF.md
# Touch Coordinate Calibration Mapper

This block converts raw resistive-panel readings into display pixel coordinates. Each accepted raw pair is mapped with a linear transform. The transform uses four signed working bounds (left, right, top, bottom) and the display width and height. Each axis is computed as a scaled offset from the low bound, divided by the bound span. The division is signed and truncates toward zero. A single shared multi-cycle sequential divider does every division, so the mapped result appears after a fixed number of cycles.

A calibration run starts with a pulse on `cal_start` and a sample count. Each iteration collects one raw pair at the near target, at one fifth of the screen, and then one raw pair at the far target, at four fifths. The block reports which target it expects next. Each corner estimate is refined as a running mean. When all iterations are done, the measured span on each axis is split into thirds, and one third is added past each end. The four results are loaded into the working bounds in a single cycle, and `cal_done` pulses.

Top module: `touch_cal_mapper`

## Requirements
- R1: After reset, the working bounds are left = RST_LEFT, right = RST_RIGHT, top = RST_TOP and bottom = RST_BOTTOM. In the idle state `raw_ready` is 1, and `out_valid`, `cal_done` and `out_err` are 0.
- R2: For a mapped sample, `out_x` equals disp_w * (raw_x - left) / (right - left). The division is signed and truncates toward zero. The result may be negative or larger than disp_w.
- R3: For a mapped sample, `out_y` equals disp_h * (raw_y - top) / (bottom - top), with the same signed truncating division.
- R4: `out_valid` is high for exactly one cycle, once both quotients are complete. `raw_ready` stays low from the cycle after acceptance until the result has been presented.
- R5: When right equals left, `out_x` is 0 and `out_err` is 1, and the same holds for Y when bottom equals top. The other axis is still mapped normally, and `out_err` is 0 when neither span is zero. A zero span is never passed to the divider.
- R6: In the idle state, a `cal_start` pulse with no raw sample taken in the same cycle starts a calibration run. During the run, `cal_target_sel` is 0 while the near target (1/5) sample is awaited and 1 while the far target (4/5) sample is awaited. In every iteration the near target comes first. Raw samples taken during calibration never cause `out_valid`.
- R7: In iteration i (counting from 0), each corner estimate is updated as (old * i + raw) / (i + 1). Left and top come from the near-target samples, and right and bottom come from the far-target samples. All estimates start at 0.
- R8: After `cal_count` iterations, the new bounds are: left = L - (R-L)/3, right = R + (R-L)/3, top = T - (B-T)/3, bottom = B + (B-T)/3, each division truncating toward zero. They replace the working bounds only in the cycle where `cal_done` pulses for one cycle, and the working bounds do not change in any other cycle.
- R9: A calibration run with `cal_count` = 0 finishes with all four bounds equal to 0.
- R10: A `cal_start` pulse while a mapping is in progress is ignored: the next raw sample is mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_w | input | DIM_W | Display width in pixels |
| disp_h | input | DIM_W | Display height in pixels |
| raw_valid | input | 1 | Raw sample offered |
| raw_ready | output | 1 | Block can take a raw sample |
| raw_x | input | RAW_W | Raw X reading (unsigned) |
| raw_y | input | RAW_W | Raw Y reading (unsigned) |
| cal_start | input | 1 | Start a calibration run |
| cal_count | input | CNT_W | Number of calibration iterations |
| cal_target_sel | output | 1 | Expected target: 0 near (1/5), 1 far (4/5) |
| out_valid | output | 1 | Mapped coordinate valid, one-cycle pulse |
| out_x | output | NUM_W | Mapped X (signed) |
| out_y | output | NUM_W | Mapped Y (signed) |
| out_err | output | 1 | A zero span forced an axis to 0 |
| cal_done | output | 1 | Calibration finished, bounds loaded |

## Verification
The bench keeps the default 12-bit raw readings and 11-bit display size, and it narrows the iteration count width to 3 bits. This keeps calibration runs short while still reaching multi-iteration running means.

With the default reset bounds spanning the full raw range, directed end-point mappings and random mappings exercise R1 to R4. Further calibrations cover the remaining cases:
- reversed targets, which give negative spans, negative quotients and truncation toward zero;
- identical X samples, which give a zero span;
- a zero iteration count.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CWAIT,
    ST_ISSUE,
    ST_DWAIT,
    ST_EMIT,
    ST_COMMIT
  } tcm_state_e;

  typedef enum logic [2:0] {
    OP_MX,
    OP_MY,
    OP_AL,
    OP_AT,
    OP_AR,
    OP_AB,
    OP_EX,
    OP_EY
  } tcm_op_e;

endpackage

// File: rtl/tcm_sdiv.sv
module tcm_sdiv #(
  parameter int NW = 27,
  parameter int DW = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic signed [NW-1:0] num_i,
  input  logic signed [DW-1:0] den_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic signed [NW-1:0] quo_o
);
  localparam int CNTW = $clog2(NW + 1);

  logic            busy_q, busy_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [NW-1:0]   n_q, n_d, q_q, q_d;
  logic [DW:0]     r_q, r_d;
  logic [DW-1:0]   d_q, d_d;
  logic            neg_q, neg_d, done_q, done_d;
  logic signed [NW-1:0] quo_q, quo_d;

  logic [DW:0]   r_sh, r_diff;
  logic          ge;
  logic [NW-1:0] q_fin;

  always_comb begin
    r_sh   = {r_q[DW-1:0], n_q[NW-1]};
    r_diff = r_sh - {1'b0, d_q};
    ge     = (r_sh >= {1'b0, d_q});
    q_fin  = {q_q[NW-2:0], ge};

    busy_d = busy_q;
    cnt_d  = cnt_q;
    n_d    = n_q;
    q_d    = q_q;
    r_d    = r_q;
    d_d    = d_q;
    neg_d  = neg_q;
    quo_d  = quo_q;
    done_d = 1'b0;

    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNTW'(NW);
      n_d    = num_i[NW-1] ? $unsigned(-num_i) : $unsigned(num_i);
      d_d    = den_i[DW-1] ? $unsigned(-den_i) : $unsigned(den_i);
      neg_d  = num_i[NW-1] ^ den_i[DW-1];
      r_d    = '0;
      q_d    = '0;
    end else if (busy_q) begin
      n_d   = {n_q[NW-2:0], 1'b0};
      r_d   = ge ? r_diff : r_sh;
      q_d   = q_fin;
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        quo_d  = neg_q ? -$signed(q_fin) : $signed(q_fin);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      n_q    <= '0;
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
      quo_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      n_q    <= n_d;
      q_q    <= q_d;
      r_q    <= r_d;
      d_q    <= d_d;
      neg_q  <= neg_d;
      done_q <= done_d;
      quo_q  <= quo_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R4: a new division is never launched on top of a running one
  p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

  // R4: completion only follows a busy interval
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q));

  // R5: zero divisors never reach the divider
  p_nonzero_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (den_i != '0));

endmodule

// File: rtl/tcm_bounds.sv
module tcm_bounds #(
  parameter int BW  = 14,
  parameter int L0  = 0,
  parameter int R0  = 4095,
  parameter int T0  = 0,
  parameter int B0  = 4095
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_i,
  input  logic signed [BW-1:0] l_i,
  input  logic signed [BW-1:0] r_i,
  input  logic signed [BW-1:0] t_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [BW-1:0] l_o,
  output logic signed [BW-1:0] r_o,
  output logic signed [BW-1:0] t_o,
  output logic signed [BW-1:0] b_o
);
  logic signed [BW-1:0] l_q, r_q, t_q, b_q;
  logic signed [BW-1:0] l_d, r_d, t_d, b_d;

  always_comb begin
    l_d = l_q;
    r_d = r_q;
    t_d = t_q;
    b_d = b_q;
    if (ld_i) begin
      l_d = l_i;
      r_d = r_i;
      t_d = t_i;
      b_d = b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= BW'(L0);
      r_q <= BW'(R0);
      t_q <= BW'(T0);
      b_q <= BW'(B0);
    end else begin
      l_q <= l_d;
      r_q <= r_d;
      t_q <= t_d;
      b_q <= b_d;
    end
  end

  assign l_o = l_q;
  assign r_o = r_q;
  assign t_o = t_q;
  assign b_o = b_q;

  // R8: working bounds move only on the commit cycle
  p_bounds_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable({l_q, r_q, t_q, b_q}));

endmodule

// File: rtl/tcm_seq.sv
module tcm_seq
  import tcm_pkg::*;
#(
  parameter int RW = 12,
  parameter int WW = 11,
  parameter int CW = 4,
  parameter int BW = 14,
  parameter int DW = 15,
  parameter int NW = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WW-1:0]        disp_w_i,
  input  logic [WW-1:0]        disp_h_i,
  input  logic                 raw_valid_i,
  output logic                 raw_ready_o,
  input  logic [RW-1:0]        raw_x_i,
  input  logic [RW-1:0]        raw_y_i,
  input  logic                 cal_start_i,
  input  logic [CW-1:0]        cal_count_i,
  output logic                 cal_target_sel_o,
  input  logic signed [BW-1:0] bnd_l_i,
  input  logic signed [BW-1:0] bnd_r_i,
  input  logic signed [BW-1:0] bnd_t_i,
  input  logic signed [BW-1:0] bnd_b_i,
  output logic                 ld_o,
  output logic signed [BW-1:0] new_l_o,
  output logic signed [BW-1:0] new_r_o,
  output logic signed [BW-1:0] new_t_o,
  output logic signed [BW-1:0] new_b_o,
  output logic                 div_start_o,
  output logic signed [NW-1:0] div_num_o,
  output logic signed [DW-1:0] div_den_o,
  input  logic                 div_busy_i,
  input  logic                 div_done_i,
  input  logic signed [NW-1:0] div_quo_i,
  output logic                 out_valid_o,
  output logic signed [NW-1:0] out_x_o,
  output logic signed [NW-1:0] out_y_o,
  output logic                 out_err_o,
  output logic                 cal_done_o
);
  tcm_state_e st_q, st_d;
  tcm_op_e    op_q, op_d;
  logic            tsel_q, tsel_d;
  logic [CW-1:0]   iter_q, iter_d, cnt_q, cnt_d;
  logic [RW-1:0]   sx_q, sx_d, sy_q, sy_d;
  logic signed [BW-1:0] acl_q, acl_d, act_q, act_d, acr_q, acr_d, acb_q, acb_d;
  logic signed [BW-1:0] dx_q, dx_d, dy_q, dy_d;
  logic signed [NW-1:0] rx_q, rx_d, ry_q, ry_d;
  logic            err_q, err_d;

  // operand preparation
  logic signed [NW-1:0] sx_e, sy_e, w_e, h_e, lb_e, tb_e, it_e;
  logic signed [NW-1:0] acl_e, act_e, acr_e, acb_e;
  logic signed [DW-1:0] span_x, span_y, inc;
  logic                 zsk;
  logic                 fin;
  logic signed [NW-1:0] fv;

  always_comb begin
    sx_e  = $signed({{(NW-RW){1'b0}}, sx_q});
    sy_e  = $signed({{(NW-RW){1'b0}}, sy_q});
    w_e   = $signed({{(NW-WW){1'b0}}, disp_w_i});
    h_e   = $signed({{(NW-WW){1'b0}}, disp_h_i});
    lb_e  = {{(NW-BW){bnd_l_i[BW-1]}}, bnd_l_i};
    tb_e  = {{(NW-BW){bnd_t_i[BW-1]}}, bnd_t_i};
    it_e  = $signed({{(NW-CW){1'b0}}, iter_q});
    acl_e = {{(NW-BW){acl_q[BW-1]}}, acl_q};
    act_e = {{(NW-BW){act_q[BW-1]}}, act_q};
    acr_e = {{(NW-BW){acr_q[BW-1]}}, acr_q};
    acb_e = {{(NW-BW){acb_q[BW-1]}}, acb_q};
    span_x = {bnd_r_i[BW-1], bnd_r_i} - {bnd_l_i[BW-1], bnd_l_i};
    span_y = {bnd_b_i[BW-1], bnd_b_i} - {bnd_t_i[BW-1], bnd_t_i};
    inc    = $signed({{(DW-CW){1'b0}}, iter_q}) + DW'(1);

    zsk = 1'b0;
    case (op_q)
      OP_MX: begin
        div_num_o = w_e * (sx_e - lb_e);
        div_den_o = span_x;
        zsk       = (span_x == '0);
      end
      OP_MY: begin
        div_num_o = h_e * (sy_e - tb_e);
        div_den_o = span_y;
        zsk       = (span_y == '0);
      end
      OP_AL: begin
        div_num_o = acl_e * it_e + sx_e;
        div_den_o = inc;
      end
      OP_AT: begin
        div_num_o = act_e * it_e + sy_e;
        div_den_o = inc;
      end
      OP_AR: begin
        div_num_o = acr_e * it_e + sx_e;
        div_den_o = inc;
      end
      OP_AB: begin
        div_num_o = acb_e * it_e + sy_e;
        div_den_o = inc;
      end
      OP_EX: begin
        div_num_o = acr_e - acl_e;
        div_den_o = DW'(3);
      end
      default: begin
        div_num_o = acb_e - act_e;
        div_den_o = DW'(3);
      end
    endcase
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    tsel_d = tsel_q;
    iter_d = iter_q;
    cnt_d  = cnt_q;
    sx_d   = sx_q;
    sy_d   = sy_q;
    acl_d  = acl_q;
    act_d  = act_q;
    acr_d  = acr_q;
    acb_d  = acb_q;
    dx_d   = dx_q;
    dy_d   = dy_q;
    rx_d   = rx_q;
    ry_d   = ry_q;
    err_d  = err_q;
    div_start_o = 1'b0;
    fin    = 1'b0;
    fv     = '0;

    case (st_q)
      ST_IDLE: begin
        if (raw_valid_i) begin
          sx_d  = raw_x_i;
          sy_d  = raw_y_i;
          err_d = 1'b0;
          op_d  = OP_MX;
          st_d  = ST_ISSUE;
        end else if (cal_start_i) begin
          cnt_d  = cal_count_i;
          iter_d = '0;
          tsel_d = 1'b0;
          acl_d  = '0;
          act_d  = '0;
          acr_d  = '0;
          acb_d  = '0;
          if (cal_count_i == '0) begin
            op_d = OP_EX;
            st_d = ST_ISSUE;
          end else begin
            st_d = ST_CWAIT;
          end
        end
      end
      ST_CWAIT: begin
        if (raw_valid_i) begin
          sx_d = raw_x_i;
          sy_d = raw_y_i;
          op_d = tsel_q ? OP_AR : OP_AL;
          st_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (zsk) begin
          fin   = 1'b1;
          err_d = 1'b1;
        end else begin
          div_start_o = 1'b1;
          st_d        = ST_DWAIT;
        end
      end
      ST_DWAIT: begin
        if (div_done_i) begin
          fin = 1'b1;
          fv  = div_quo_i;
        end
      end
      ST_EMIT:   st_d = ST_IDLE;
      ST_COMMIT: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase

    if (fin) begin
      case (op_q)
        OP_MX: begin
          rx_d = fv;
          op_d = OP_MY;
          st_d = ST_ISSUE;
        end
        OP_MY: begin
          ry_d = fv;
          st_d = ST_EMIT;
        end
        OP_AL: begin
          acl_d = fv[BW-1:0];
          op_d  = OP_AT;
          st_d  = ST_ISSUE;
        end
        OP_AT: begin
          act_d  = fv[BW-1:0];
          tsel_d = 1'b1;
          st_d   = ST_CWAIT;
        end
        OP_AR: begin
          acr_d = fv[BW-1:0];
          op_d  = OP_AB;
          st_d  = ST_ISSUE;
        end
        OP_AB: begin
          acb_d  = fv[BW-1:0];
          iter_d = iter_q + 1'b1;
          tsel_d = 1'b0;
          if (({1'b0, iter_q} + 1'b1) == {1'b0, cnt_q}) begin
            op_d = OP_EX;
            st_d = ST_ISSUE;
          end else begin
            st_d = ST_CWAIT;
          end
        end
        OP_EX: begin
          dx_d = fv[BW-1:0];
          op_d = OP_EY;
          st_d = ST_ISSUE;
        end
        default: begin
          dy_d = fv[BW-1:0];
          st_d = ST_COMMIT;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_MX;
      tsel_q <= 1'b0;
      iter_q <= '0;
      cnt_q  <= '0;
      sx_q   <= '0;
      sy_q   <= '0;
      acl_q  <= '0;
      act_q  <= '0;
      acr_q  <= '0;
      acb_q  <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      rx_q   <= '0;
      ry_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      tsel_q <= tsel_d;
      iter_q <= iter_d;
      cnt_q  <= cnt_d;
      sx_q   <= sx_d;
      sy_q   <= sy_d;
      acl_q  <= acl_d;
      act_q  <= act_d;
      acr_q  <= acr_d;
      acb_q  <= acb_d;
      dx_q   <= dx_d;
      dy_q   <= dy_d;
      rx_q   <= rx_d;
      ry_q   <= ry_d;
      err_q  <= err_d;
    end
  end

  assign raw_ready_o      = (st_q == ST_IDLE) || (st_q == ST_CWAIT);
  assign cal_target_sel_o = tsel_q;
  assign out_valid_o      = (st_q == ST_EMIT);
  assign cal_done_o       = (st_q == ST_COMMIT);
  assign out_x_o          = rx_q;
  assign out_y_o          = ry_q;
  assign out_err_o        = err_q;
  assign ld_o             = (st_q == ST_COMMIT);
  assign new_l_o          = acl_q - dx_q;
  assign new_r_o          = acr_q + dx_q;
  assign new_t_o          = act_q - dy_q;
  assign new_b_o          = acb_q + dy_q;

  // R4: result strobe lasts a single cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  // R4: no sample is taken while the divider works
  p_ready_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_ready_o |-> !div_busy_i);

  // R5: zero X span gives a zero X result with the error flag
  p_zero_span_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && (bnd_r_i == bnd_l_i)) |-> (out_err_o && (out_x_o == '0)));

  // R5: zero Y span gives a zero Y result with the error flag
  p_zero_span_y_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && (bnd_b_i == bnd_t_i)) |-> (out_err_o && (out_y_o == '0)));

  // R8: completion strobe lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_done_o);

  // R6: mapping strobe and calibration completion never coincide
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid_o && cal_done_o));

endmodule

// File: rtl/touch_cal_mapper.sv
module touch_cal_mapper #(
  parameter int RAW_W      = 12,
  parameter int DIM_W      = 11,
  parameter int CNT_W      = 4,
  parameter int RST_LEFT   = 0,
  parameter int RST_RIGHT  = 4095,
  parameter int RST_TOP    = 0,
  parameter int RST_BOTTOM = 4095,
  localparam int BND_W     = RAW_W + 2,
  localparam int DEN_W     = BND_W + 1,
  localparam int NUM_W     = DIM_W + BND_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIM_W-1:0]        disp_w,
  input  logic [DIM_W-1:0]        disp_h,
  input  logic                    raw_valid,
  output logic                    raw_ready,
  input  logic [RAW_W-1:0]        raw_x,
  input  logic [RAW_W-1:0]        raw_y,
  input  logic                    cal_start,
  input  logic [CNT_W-1:0]        cal_count,
  output logic                    cal_target_sel,
  output logic                    out_valid,
  output logic signed [NUM_W-1:0] out_x,
  output logic signed [NUM_W-1:0] out_y,
  output logic                    out_err,
  output logic                    cal_done
);
  logic                    ld;
  logic signed [BND_W-1:0] bl, br, bt, bb;
  logic signed [BND_W-1:0] nl, nr, nt, nb;
  logic                    dstart, dbusy, ddone;
  logic signed [NUM_W-1:0] dnum, dquo;
  logic signed [DEN_W-1:0] dden;

  tcm_bounds #(
    .BW(BND_W), .L0(RST_LEFT), .R0(RST_RIGHT), .T0(RST_TOP), .B0(RST_BOTTOM)
  ) u_bounds (
    .clk(clk), .rst_n(rst_n), .ld_i(ld),
    .l_i(nl), .r_i(nr), .t_i(nt), .b_i(nb),
    .l_o(bl), .r_o(br), .t_o(bt), .b_o(bb)
  );

  tcm_sdiv #(.NW(NUM_W), .DW(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(dstart), .num_i(dnum), .den_i(dden),
    .busy_o(dbusy), .done_o(ddone), .quo_o(dquo)
  );

  tcm_seq #(
    .RW(RAW_W), .WW(DIM_W), .CW(CNT_W), .BW(BND_W), .DW(DEN_W), .NW(NUM_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .disp_w_i(disp_w), .disp_h_i(disp_h),
    .raw_valid_i(raw_valid), .raw_ready_o(raw_ready),
    .raw_x_i(raw_x), .raw_y_i(raw_y),
    .cal_start_i(cal_start), .cal_count_i(cal_count),
    .cal_target_sel_o(cal_target_sel),
    .bnd_l_i(bl), .bnd_r_i(br), .bnd_t_i(bt), .bnd_b_i(bb),
    .ld_o(ld), .new_l_o(nl), .new_r_o(nr), .new_t_o(nt), .new_b_o(nb),
    .div_start_o(dstart), .div_num_o(dnum), .div_den_o(dden),
    .div_busy_i(dbusy), .div_done_i(ddone), .div_quo_i(dquo),
    .out_valid_o(out_valid), .out_x_o(out_x), .out_y_o(out_y),
    .out_err_o(out_err), .cal_done_o(cal_done)
  );

endmodule

// File: tb/touch_cal_mapper_test.sv
module touch_cal_mapper_test;
  localparam int RW = 12;
  localparam int WW = 11;
  localparam int CW = 3;
  localparam int QW = WW + RW + 2 + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WW-1:0] disp_w = '0, disp_h = '0;
  logic raw_valid = 1'b0;
  logic raw_ready;
  logic [RW-1:0] raw_x = '0, raw_y = '0;
  logic cal_start = 1'b0;
  logic [CW-1:0] cal_count = '0;
  logic cal_target_sel, out_valid, out_err, cal_done;
  logic signed [QW-1:0] out_x, out_y;

  touch_cal_mapper #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .disp_w(disp_w), .disp_h(disp_h),
    .raw_valid(raw_valid), .raw_ready(raw_ready), .raw_x(raw_x), .raw_y(raw_y),
    .cal_start(cal_start), .cal_count(cal_count), .cal_target_sel(cal_target_sel),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_err(out_err),
    .cal_done(cal_done)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, n_ov = 0;
  int m_l = 0, m_r = 4095, m_t = 0, m_b = 4095;
  int seed_sink;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog expired: actual=%0d cycles expected<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) if (out_valid) n_ov++;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mapc(int d, int raw, int lo, int hi);
    if (hi == lo) return 0;
    return (d * (raw - lo)) / (hi - lo);
  endfunction

  task automatic send(int x, int y, int exp_sel);
    int wd = 0;
    @(negedge clk);
    raw_x = x[RW-1:0]; raw_y = y[RW-1:0]; raw_valid = 1'b1;
    while (!raw_ready && wd < 2000) begin @(negedge clk); wd++; end
    if (exp_sel >= 0) chk("R6 target select", int'(cal_target_sel), exp_sel);
    @(posedge clk);
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic wait_out(output bit got);
    int wd = 0;
    while (!out_valid && wd < 500) begin @(negedge clk); wd++; end
    got = out_valid;
  endtask

  task automatic map_chk(int x, int y);
    bit got;
    int ee;
    send(x, y, -1);
    wait_out(got);
    chk("R4 out_valid seen", int'(got), 1);
    if (got) begin
      ee = ((m_r == m_l) || (m_b == m_t)) ? 1 : 0;
      chk("R2 out_x", int'(out_x), mapc(int'(disp_w), x, m_l, m_r));
      chk("R3 out_y", int'(out_y), mapc(int'(disp_h), y, m_t, m_b));
      chk("R5 out_err", int'(out_err), ee);
      @(negedge clk);
      chk("R4 single-cycle valid", int'(out_valid), 0);
    end
  endtask

  task automatic calib(int cnt, int mode);
    int l = 0, r = 0, t = 0, b = 0, dx, dy, wd, ov0;
    ov0 = n_ov;
    @(negedge clk);
    cal_count = cnt[CW-1:0]; cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      int ax, ay, bx, by;
      ay = $urandom_range(300, 1200); by = $urandom_range(2900, 3800);
      case (mode)
        1: begin ax = $urandom_range(2900, 3800); bx = $urandom_range(300, 1200); end
        2: begin ax = 1000; bx = 1000; end
        default: begin ax = $urandom_range(300, 1200); bx = $urandom_range(2900, 3800); end
      endcase
      send(ax, ay, 0);
      send(bx, by, 1);
      l = (l * i + ax) / (i + 1); t = (t * i + ay) / (i + 1);
      r = (r * i + bx) / (i + 1); b = (b * i + by) / (i + 1);
    end
    wd = 0;
    while (!cal_done && wd < 2000) begin @(negedge clk); wd++; end
    chk("R8 cal_done seen", int'(cal_done), 1);
    @(negedge clk);
    chk("R8 cal_done single cycle", int'(cal_done), 0);
    chk("R6 no out_valid during calibration", n_ov - ov0, 0);
    dx = (r - l) / 3; dy = (b - t) / 3;
    m_l = l - dx; m_r = r + dx; m_t = t - dy; m_b = b + dy;
  endtask

  initial begin
    bit got;
    seed_sink = $urandom(32'd20240517);
    disp_w = 11'd2000; disp_h = 11'd1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 raw_ready", int'(raw_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 cal_done", int'(cal_done), 0);
    chk("R1 out_err", int'(out_err), 0);
    // R1 default bounds through mapping end points
    map_chk(0, 0);
    map_chk(4095, 4095);
    map_chk(2048, 1);
    // R2 R3 random mapping with default bounds
    for (int k = 0; k < 12; k++) begin
      disp_w = WW'($urandom_range(1, 2047)); disp_h = WW'($urandom_range(1, 2047));
      map_chk($urandom_range(0, 4095), $urandom_range(0, 4095));
    end
    // R7 R8 multi-iteration calibration then mapping
    disp_w = 11'd800; disp_h = 11'd480;
    calib(3, 0);
    map_chk(m_l < 0 ? 0 : m_l, m_t < 0 ? 0 : m_t);
    for (int k = 0; k < 8; k++) map_chk($urandom_range(0, 4095), $urandom_range(0, 4095));
    // R8 reversed X targets: negative span and negative quotients
    calib(2, 1);
    for (int k = 0; k < 8; k++) map_chk($urandom_range(0, 4095), $urandom_range(0, 4095));
    // R10 cal_start during mapping is ignored
    send(1234, 2345, -1);
    @(negedge clk); cal_start = 1'b1; cal_count = 3'd2;
    @(negedge clk); cal_start = 1'b0;
    wait_out(got);
    chk("R10 mapping completes", int'(got), 1);
    @(negedge clk);
    map_chk(3000, 700);
    // R5 zero X span
    calib(2, 2);
    chk("R5 model X span zero", m_r - m_l, 0);
    map_chk(1500, 2000);
    map_chk(1000, 3500);
    // R9 zero iteration count
    calib(0, 0);
    chk("R9 left", m_l, 0);
    map_chk(4000, 4000);
    // back to a normal calibration, single iteration
    calib(1, 0);
    for (int k = 0; k < 6; k++) map_chk($urandom_range(0, 4095), $urandom_range(0, 4095));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule